// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind a serial-bus protocol engine in a byte-addressed nonvolatile memory. When the engine decodes a write transfer, it hands over the starting word address. Each data byte that arrives after that is placed in a page-sized holding buffer, at the buffer slot given by the low part of a running address. After each byte, only the low part of that address advances, and it wraps inside the page, so a long transfer overwrites its own earlier bytes. The upper address bits select the page and never change during a transfer.

A stop condition that closes a write transfer holding at least one byte starts a write cycle. The cycle lasts a fixed, parameterized number of clocks. During the cycle the block streams every byte that was written in the transfer, and only those, to a memory write port. A busy flag is raised for the whole cycle. The protocol engine uses it to withhold acknowledges, so a master finds the end of the cycle by acknowledge polling. While busy, the block ignores every event from the bus side. A write-protect input keeps the array unchanged.

Top module: `page_commit_buffer`

## Requirements
- R1: A byte accepted while a write transfer is open is stored at page slot equal to the low PAGE_AW bits of the running address; at commit it is written to memory address {upper bits, slot}, where the upper bits are the top ADDR_W-PAGE_AW bits of the transfer's start address.
- R2: After each accepted byte the low PAGE_AW address bits increment by one and the upper bits are unchanged.
- R3: When the low bits are all ones, the next accepted byte moves them to zero in the same page; a later byte to a slot replaces the earlier one, so the last value sent to each slot is the one committed.
- R4: A write cycle starts only when stop_evt ends an open write transfer that accepted at least one byte; busy is high in the first cycle after the clock edge that samples stop_evt; a transfer with no data bytes starts no cycle.
- R5: busy stays high for exactly WR_CYCLES consecutive clock cycles per write cycle.
- R6: While busy is high, wr_begin, byte_valid, stop_evt and start_evt have no effect: no byte is stored, no extra cycle follows, and the committed data is unchanged.
- R7: After busy falls, the next wr_begin opens a write transfer that is collected and committed normally.
- R8: When wp is high at the stop, no write cycle starts; mem_we is never high while wp is high, so a cycle running with wp high changes no memory location.
- R9: Only slots written in the current transfer are committed. wr_begin clears the per-slot valid mask, so bytes from earlier transfers are never written again.
- R10: A start_evt during an open write transfer closes it without a commit; bytes after it are not stored, and a following stop_evt starts no cycle.
- R11: After reset busy and mem_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_begin | input | 1 | Pulse: a write transfer opens at start_addr |
| start_addr | input | ADDR_W | Word address of the first data byte |
| byte_valid | input | 1 | Pulse: byte_data is a received data byte |
| byte_data | input | DATA_W | Received data byte |
| stop_evt | input | 1 | Pulse: stop condition seen on the bus |
| start_evt | input | 1 | Pulse: start condition seen on the bus |
| wp | input | 1 | Write protect, high blocks all commits |
| busy | output | 1 | Write cycle running; acknowledges must be withheld |
| mem_we | output | 1 | Memory array write strobe |
| mem_addr | output | ADDR_W | Memory array write address |
| mem_wdata | output | DATA_W | Memory array write data |

## Verification
On every cycle the assertions check that a write cycle begins only right after a stop with protection off, that each cycle lasts its full count, that the page bits stay fixed and the low bits wrap to zero, that wr_begin empties the valid mask, and that the mask is frozen while busy. Which bytes reach which addresses, the last-value-wins result of a wrapping transfer, and the discarding of bytes held over a repeated start show up only in the memory contents. The bench sweeps every start address of a small configuration with short, page-length and wrapping transfers, and compares a full memory image computed arithmetically. It also runs the protected, interrupted and busy-time stimulus scenarios.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  // Transfer tracking; the write cycle itself is tracked by the timer.
  typedef enum logic [1:0] {
    XF_IDLE,   // no write transfer open
    XF_FILL,   // write transfer open, bytes accepted
    XF_HELD    // closed by a repeated start, nothing to commit
  } xfer_state_e;

endpackage

// File: rtl/pcb_addr_ctr.sv
module pcb_addr_ctr #(
  parameter int ADDR_W  = 17,
  parameter int PAGE_AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [ADDR_W-1:0]         load_addr,
  input  logic                      step,
  output logic [PAGE_AW-1:0]        lo,
  output logic [ADDR_W-PAGE_AW-1:0] hi
);
  localparam int HI_W = ADDR_W - PAGE_AW;

  // Low part advances modulo the page size; no carry into the page bits.
  function automatic logic [PAGE_AW-1:0] lo_after(input logic [PAGE_AW-1:0] cur);
    return cur + 1'b1;
  endfunction

  logic [PAGE_AW-1:0] lo_q;
  logic [HI_W-1:0]    hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      {hi_q, lo_q} <= load_addr;
    end else if (step) begin
      lo_q <= lo_after(lo_q);
    end
  end

  assign lo = lo_q;
  assign hi = hi_q;

  // R2: page bits hold while bytes are stepped in
  p_hi_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> $stable(hi_q));

  // R3: the last slot wraps to slot zero of the same page
  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (&lo_q)) |=> (lo_q == '0));

endmodule

// File: rtl/pcb_page_store.sv
module pcb_page_store #(
  parameter int PAGE_AW = 8,
  parameter int DATA_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [PAGE_AW-1:0]      wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [PAGE_AW-1:0]      rd_idx,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_valid,
  output logic [(1<<PAGE_AW)-1:0] mask
);
  localparam int DEPTH = 1 << PAGE_AW;

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  mask_q;

  // Data slots carry no reset; the mask says which are meaningful.
  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (clear)  mask_q <= '0;
    else if (wr_en)  mask_q[wr_idx] <= 1'b1;
  end

  assign rd_data  = slot_q[rd_idx];
  assign rd_valid = mask_q[rd_idx];
  assign mask     = mask_q;

endmodule

// File: rtl/pcb_commit_timer.sv
module pcb_commit_timer #(
  parameter int WR_CYCLES = 1200,
  parameter int PAGE_AW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  output logic               running,
  output logic               scan_on,
  output logic [PAGE_AW-1:0] scan_idx
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam int SPAN  = 1 << PAGE_AW;

  function automatic logic is_final(input logic [CNT_W-1:0] c);
    return c == CNT_W'(WR_CYCLES - 1);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             final_cycle;

  assign final_cycle = run_q && is_final(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (launch) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (final_cycle) run_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // The first SPAN cycles of the timed window walk the page slots.
  assign running  = run_q;
  assign scan_on  = run_q && (32'(cnt_q) < SPAN);
  assign scan_idx = PAGE_AW'(cnt_q);

  // R5: a cycle only ends after its full count
  p_full_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(cnt_q) == CNT_W'(WR_CYCLES - 1)));

endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int ADDR_W    = 17,
  parameter int PAGE_AW   = 8,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 1200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_begin,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_evt,
  input  logic              start_evt,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  import pcb_pkg::*;

  localparam int HI_W  = ADDR_W - PAGE_AW;
  localparam int DEPTH = 1 << PAGE_AW;

  xfer_state_e        xf_q, xf_d;
  logic [PAGE_AW-1:0] lo;
  logic [HI_W-1:0]    hi;
  logic               running, scan_on;
  logic [PAGE_AW-1:0] scan_idx;
  logic [DATA_W-1:0]  slot_data;
  logic               slot_valid;
  logic [DEPTH-1:0]   mask;

  // Named events for the assertions; every bus-side event is gated by busy.
  logic begin_take, byte_take, stop_take, start_take, launch;

  assign begin_take = wr_begin & ~running;
  assign byte_take  = byte_valid & ~running & ~wr_begin & (xf_q == XF_FILL);
  assign stop_take  = stop_evt & ~running;
  assign start_take = start_evt & ~running;
  assign launch     = stop_take & ~begin_take & (xf_q == XF_FILL) & (|mask) & ~wp;

  always_comb begin
    xf_d = xf_q;
    if (begin_take)                            xf_d = XF_FILL;
    else if (stop_take)                        xf_d = XF_IDLE;
    else if (start_take && xf_q == XF_FILL)    xf_d = XF_HELD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xf_q <= XF_IDLE;
    else        xf_q <= xf_d;
  end

  pcb_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) addr_i (
    .clk(clk), .rst_n(rst_n), .load(begin_take), .load_addr(start_addr),
    .step(byte_take), .lo(lo), .hi(hi)
  );

  pcb_page_store #(.PAGE_AW(PAGE_AW), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n), .clear(begin_take), .wr_en(byte_take),
    .wr_idx(lo), .wr_data(byte_data), .rd_idx(scan_idx),
    .rd_data(slot_data), .rd_valid(slot_valid), .mask(mask)
  );

  pcb_commit_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_AW(PAGE_AW)) timer_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .running(running),
    .scan_on(scan_on), .scan_idx(scan_idx)
  );

  assign busy      = running;
  assign mem_we    = running & scan_on & slot_valid & ~wp;
  assign mem_addr  = {hi, scan_idx};
  assign mem_wdata = slot_data;

  // R4: a cycle begins only on the edge after a stop
  p_cycle_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  // R8: no cycle is started while protected
  p_no_cycle_protected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp));

  // R6: bus events cannot touch the held bytes during a cycle
  p_mask_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mask));

  // R9: opening a transfer empties the valid mask
  p_mask_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    begin_take |=> (mask == '0));

endmodule

// File: tb/page_commit_buffer_tb.sv
module page_commit_buffer_tb_top;
  localparam int AW = 6, PAW = 3, DW = 8, WRC = 12;
  localparam int PG = 1 << PAW, MSZ = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_begin = 0, byte_valid = 0, stop_evt = 0, start_evt = 0, wp = 0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] byte_data = '0;
  logic busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int vectors = 0, fails = 0, cyc = 0;
  logic [DW-1:0] bmem [MSZ];
  logic [DW-1:0] emem [MSZ];

  always #2.5 clk = ~clk;

  page_commit_buffer #(.ADDR_W(AW), .PAGE_AW(PAW), .DATA_W(DW), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop_evt(stop_evt),
    .start_evt(start_evt), .wp(wp), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // Backing array model written through the memory port
  always @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dval(input int tag, input int i);
    return DW'((tag * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic cmp_mem(input string req);
    int bad = -1;
    for (int a = 0; a < MSZ; a++) if (bad < 0 && bmem[a] !== emem[a]) bad = a;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, int'(bmem[bad]), int'(emem[bad]));
  endtask

  task automatic send_begin(input int sa);
    wr_begin = 1; start_addr = AW'(sa); @(negedge clk); wr_begin = 0;
  endtask
  task automatic feed(input logic [DW-1:0] d);
    byte_valid = 1; byte_data = d; @(negedge clk); byte_valid = 0;
  endtask
  task automatic stop_p();
    stop_evt = 1; @(negedge clk); stop_evt = 0;
  endtask
  task automatic start_p();
    start_evt = 1; @(negedge clk); start_evt = 0;
  endtask

  // Counts busy cycles; optionally injects all bus events on busy cycle 2.
  task automatic measure(output int len, input bit inject);
    len = 0;
    while (busy && len < 100) begin
      if (inject && len == 2) begin
        wr_begin = 1; start_addr = '0; byte_valid = 1; byte_data = 8'hAA;
        stop_evt = 1; start_evt = 1;
      end else begin
        wr_begin = 0; byte_valid = 0; stop_evt = 0; start_evt = 0;
      end
      len++;
      @(negedge clk);
    end
    wr_begin = 0; byte_valid = 0; stop_evt = 0; start_evt = 0;
  endtask

  task automatic idle_busy_check(input int n, input string req);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      if (busy) seen++;
      @(negedge clk);
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic write_xfer(input int sa, input int n, input int tag, input string req);
    int len;
    int hi = sa / PG, lo0 = sa % PG;
    send_begin(sa);
    for (int i = 0; i < n; i++) begin
      feed(dval(tag, i));
      emem[hi * PG + (lo0 + i) % PG] = dval(tag, i);
    end
    stop_p();
    chk(busy === 1'b1, "R4 busy after stop", int'(busy), 1);
    measure(len, 1'b0);
    chk(len == WRC, "R5 cycle length", len, WRC);
    cmp_mem(req);
  endtask

  initial begin
    int len;
    for (int a = 0; a < MSZ; a++) begin bmem[a] = '0; emem[a] = '0; end
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && mem_we === 1'b0, "R11 reset state", int'({busy, mem_we}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0 && mem_we === 1'b0, "R11 after release", int'({busy, mem_we}), 0);

    // Sweep every start address: single byte (R1/R9), full page (R2), wrap (R3)
    for (int a = 0; a < MSZ; a++) write_xfer(a, 1, a, "R1 R9 single byte image");
    for (int a = 0; a < MSZ; a++) write_xfer(a, PG, a + 100, "R2 full page image");
    for (int a = 0; a < MSZ; a++) write_xfer(a, PG + 3, a + 200, "R3 wrap overwrite image");

    // R4: address-only write transfer starts no cycle
    send_begin(30); stop_p();
    idle_busy_check(WRC + 3, "R4 empty transfer no cycle");
    cmp_mem("R4 empty transfer memory");

    // R8: protected at stop
    wp = 1;
    send_begin(9); feed(8'h11); feed(8'h22); feed(8'h33); stop_p();
    idle_busy_check(WRC + 3, "R8 protected no cycle");
    cmp_mem("R8 protected stop memory");
    wp = 0;

    // R8: protection raised while a cycle runs
    send_begin(20); for (int i = 0; i < 4; i++) feed(dval(77, i)); stop_p();
    wp = 1;
    measure(len, 1'b0);
    chk(len == WRC, "R8 protected cycle length", len, WRC);
    wp = 0;
    cmp_mem("R8 protected cycle memory");

    // R6: bus events during the cycle are ignored
    send_begin(5);
    feed(8'h5A); emem[5] = 8'h5A;
    feed(8'hC3); emem[6] = 8'hC3;
    stop_p();
    measure(len, 1'b1);
    chk(len == WRC, "R6 cycle length with injected events", len, WRC);
    idle_busy_check(WRC + 3, "R6 injected stop no extra cycle");
    cmp_mem("R6 injected events memory");

    // R7: a normal transfer right after the cycle
    write_xfer(40, 2, 55, "R7 transfer after cycle");

    // R10: repeated start before stop, then R9 mask cleared by next transfer
    send_begin(16); feed(8'h91); feed(8'h92); feed(8'h93);
    start_p(); feed(8'h94); stop_p();
    idle_busy_check(WRC + 3, "R10 held bytes no cycle");
    cmp_mem("R10 held bytes memory");
    send_begin(16); feed(8'hE7); emem[16] = 8'hE7; stop_p();
    measure(len, 1'b0);
    chk(len == WRC, "R9 cycle length", len, WRC);
    cmp_mem("R9 only new slot committed");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule